// File: doc/BRIEF.md
# Queue Interrupt Source Controller

This block turns the status flags of 64 hardware queues into two interrupt lines, one for the lower 32 queues and one for the upper 32. The queue datapath supplies the flags. For a lower queue, these are a nibble of four flags: empty, nearly empty, nearly full and full. For an upper queue, they are a "not nearly empty" bit and a "full" bit. The block registers these flags and watches a chosen condition for each queue. When that condition rises and the queue is enabled, the block latches a sticky status bit.

Each lower queue has a 3-bit condition code. The low two bits pick one of its four flags, and the top bit inverts the picked flag. Upper queues have no code: each one always watches its "not nearly empty" flag. Software works through a 32-bit register port with a one-cycle read latency. Through it, software programs the codes, sets the per-half enable words, clears status bits by writing ones, and reads back the captured flags.

Top module: `queue_irq_ctrl`

## Requirements
- R1: After reset, every lower flag word reads 0x33333333. All condition codes, both enable words and both status words read 0. The upper not-nearly-empty word reads 0xFFFFFFFF and the upper full word reads 0. Both interrupt outputs are low.
- R2: Condition codes sit at word offsets 0 to 3. Queue q uses word q/8, bits 4*(q%8)+2 down to 4*(q%8). Bit 4*(q%8)+3 is reserved: it reads 0 and writes to it are dropped.
- R3: For a lower queue, code bits 1:0 pick a bit of its flag nibble: 0 empty, 1 nearly empty, 2 nearly full, 3 full. Code bit 2 inverts the picked bit. A flag input change that makes this condition rise sets the queue's bit in the lower status word (offset 10). The bit is set on the second clock edge after the input change.
- R4: An upper queue's bit in the upper status word (offset 11) is set when its not-nearly-empty input rises. The timing is the same as in R3.
- R5: A rising condition on a queue whose enable bit is 0 sets nothing. The lower enable word is at offset 8 and the upper enable word is at offset 9.
- R6: Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged.
- R7: If a condition rise and a write-1 clear hit the same status bit on the same edge, the bit ends up set.
- R8: Each interrupt output is the OR of status AND enable for its half. Clearing an enable bit drops that queue's share of the interrupt but keeps its status bit.
- R9: A read returns, one cycle after the address, the value held before that edge. Offsets 14 and 15 read 0. Writes to the flag words (offsets 4 to 7, 12, 13) have no effect.
- R10: Flag words hold the inputs as registered on the previous edge. Lower queue q uses word 4+q/8, nibble q%8. The upper not-nearly-empty word is at offset 12 and the upper full word is at offset 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| lo_flags | input | 128 | Lower queue flag nibbles, queue q at bits 4q+3:4q |
| hi_nne | input | 32 | Upper queue not-nearly-empty flags |
| hi_full | input | 32 | Upper queue full flags |
| irq_lo | output | 1 | Lower half interrupt |
| irq_hi | output | 1 | Upper half interrupt |

## Verification
The bench targets the cases a wrong design would get visibly wrong:
- An inverted code (not empty) must fire on a falling flag. A design that ignores the inversion bit would never raise it.
- A condition rise that lands on the same edge as a write-1 clear must leave the bit set. A design that gives priority to the clear would lose that event silently.
- A rise on a disabled queue must leave its status bit at 0.
- After an enable bit is cleared, the interrupt line must drop while the status bit stays readable.

Reserved code bits, unmapped offsets and writes to read-only flag words are checked through readback. A design that stored or decoded them would return nonzero or altered values.

// File: rtl/qic_pkg.sv
package qic_pkg;
    localparam int HALF_Q     = 32;
    localparam int DW         = 32;
    localparam int AW         = 4;
    localparam int NIB        = 4;
    localparam int SEL_W      = 3;
    localparam int QPW        = DW / NIB;
    localparam int SEL_WORDS  = HALF_Q / QPW;
    localparam int FLAG_WORDS = (HALF_Q * NIB) / DW;

    localparam int A_SEL0    = 0;
    localparam int A_FLAG0   = A_SEL0 + SEL_WORDS;
    localparam int A_EN_LO   = A_FLAG0 + FLAG_WORDS;
    localparam int A_EN_HI   = A_EN_LO + 1;
    localparam int A_ST_LO   = A_EN_HI + 1;
    localparam int A_ST_HI   = A_ST_LO + 1;
    localparam int A_NNE_HI  = A_ST_HI + 1;
    localparam int A_FULL_HI = A_NNE_HI + 1;

    localparam logic [NIB-1:0] FLAG_RST_NIB = 4'h3;
endpackage

// File: rtl/qic_cond_mux.sv
module qic_cond_mux #(
    parameter int NQ    = 32,
    parameter int NIB   = 4,
    parameter int SEL_W = 3
) (
    input  logic [NQ*NIB-1:0]   flags,
    input  logic [NQ*SEL_W-1:0] code,
    output logic [NQ-1:0]       cond
);
    for (genvar q = 0; q < NQ; q++) begin : g_q
        logic [NIB-1:0]   nib;
        logic [SEL_W-1:0] c;
        assign nib     = flags[q*NIB +: NIB];
        assign c       = code[q*SEL_W +: SEL_W];
        assign cond[q] = nib[c[1:0]] ^ c[2];
    end
endmodule

// File: rtl/qic_half.sv
module qic_half #(
    parameter int NQ = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NQ-1:0] cond_now,
    input  logic [NQ-1:0] en,
    input  logic [NQ-1:0] clr,
    output logic [NQ-1:0] status,
    output logic          irq
);
    typedef struct packed {
        logic [NQ-1:0] prev;
        logic [NQ-1:0] stat;
    } half_st_t;

    half_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.prev = cond_now;
        s_d.stat = (s_q.stat & ~clr) | (en & cond_now & ~s_q.prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.prev <= '1;
            s_q.stat <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign status = s_q.stat;
    assign irq    = |(s_q.stat & en);
endmodule

// File: rtl/queue_irq_ctrl.sv
module queue_irq_ctrl
    import qic_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [AW-1:0]         reg_addr,
    input  logic [DW-1:0]         reg_wdata,
    output logic [DW-1:0]         reg_rdata,
    input  logic [HALF_Q*NIB-1:0] lo_flags,
    input  logic [HALF_Q-1:0]     hi_nne,
    input  logic [HALF_Q-1:0]     hi_full,
    output logic                  irq_lo,
    output logic                  irq_hi
);
    typedef struct packed {
        logic [HALF_Q*SEL_W-1:0] sel;
        logic [HALF_Q-1:0]       en_lo;
        logic [HALF_Q-1:0]       en_hi;
        logic [HALF_Q*NIB-1:0]   flags_lo;
        logic [HALF_Q-1:0]       nne_hi;
        logic [HALF_Q-1:0]       full_hi;
        logic [DW-1:0]           rdata;
    } regs_t;

    regs_t s_d, s_q;

    logic [HALF_Q-1:0] cond_lo;
    logic [HALF_Q-1:0] clr_lo, clr_hi;
    logic [HALF_Q-1:0] stat_lo, stat_hi;
    logic [HALF_Q-1:0] en_lo_q, en_hi_q, nne_q;
    logic [DW-1:0]     sel_word [SEL_WORDS];

    assign en_lo_q = s_q.en_lo;
    assign en_hi_q = s_q.en_hi;
    assign nne_q   = s_q.nne_hi;

    for (genvar w = 0; w < SEL_WORDS; w++) begin : g_selw
        for (genvar i = 0; i < QPW; i++) begin : g_nib
            assign sel_word[w][i*NIB +: NIB] =
                {1'b0, s_q.sel[(w*QPW+i)*SEL_W +: SEL_W]};
        end
    end

    qic_cond_mux #(.NQ(HALF_Q), .NIB(NIB), .SEL_W(SEL_W)) u_cmux (
        .flags (s_q.flags_lo),
        .code  (s_q.sel),
        .cond  (cond_lo)
    );

    assign clr_lo = (reg_wr && reg_addr == AW'(A_ST_LO)) ? reg_wdata : '0;
    assign clr_hi = (reg_wr && reg_addr == AW'(A_ST_HI)) ? reg_wdata : '0;

    qic_half #(.NQ(HALF_Q)) u_lo (
        .clk      (clk),
        .rst_n    (rst_n),
        .cond_now (cond_lo),
        .en       (s_q.en_lo),
        .clr      (clr_lo),
        .status   (stat_lo),
        .irq      (irq_lo)
    );

    qic_half #(.NQ(HALF_Q)) u_hi (
        .clk      (clk),
        .rst_n    (rst_n),
        .cond_now (s_q.nne_hi),
        .en       (s_q.en_hi),
        .clr      (clr_hi),
        .status   (stat_hi),
        .irq      (irq_hi)
    );

    always_comb begin
        logic [DW-1:0] rd;
        s_d = s_q;

        // read mux on pre-edge state
        rd = '0;
        for (int w = 0; w < SEL_WORDS; w++) begin
            if (reg_addr == AW'(A_SEL0 + w)) rd = sel_word[w];
        end
        for (int w = 0; w < FLAG_WORDS; w++) begin
            if (reg_addr == AW'(A_FLAG0 + w)) rd = s_q.flags_lo[w*DW +: DW];
        end
        if (reg_addr == AW'(A_EN_LO))   rd = s_q.en_lo;
        if (reg_addr == AW'(A_EN_HI))   rd = s_q.en_hi;
        if (reg_addr == AW'(A_ST_LO))   rd = stat_lo;
        if (reg_addr == AW'(A_ST_HI))   rd = stat_hi;
        if (reg_addr == AW'(A_NNE_HI))  rd = s_q.nne_hi;
        if (reg_addr == AW'(A_FULL_HI)) rd = s_q.full_hi;
        s_d.rdata = rd;

        // writable registers
        if (reg_wr) begin
            for (int w = 0; w < SEL_WORDS; w++) begin
                if (reg_addr == AW'(A_SEL0 + w)) begin
                    for (int i = 0; i < QPW; i++) begin
                        s_d.sel[(w*QPW+i)*SEL_W +: SEL_W] = reg_wdata[i*NIB +: SEL_W];
                    end
                end
            end
            if (reg_addr == AW'(A_EN_LO)) s_d.en_lo = reg_wdata;
            if (reg_addr == AW'(A_EN_HI)) s_d.en_hi = reg_wdata;
        end

        // flag capture
        s_d.flags_lo = lo_flags;
        s_d.nne_hi   = hi_nne;
        s_d.full_hi  = hi_full;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.sel      <= '0;
            s_q.en_lo    <= '0;
            s_q.en_hi    <= '0;
            s_q.flags_lo <= {HALF_Q{FLAG_RST_NIB}};
            s_q.nne_hi   <= '1;
            s_q.full_hi  <= '0;
            s_q.rdata    <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign reg_rdata = s_q.rdata;
endmodule

// File: rtl/queue_irq_ctrl_chk.sv
module queue_irq_ctrl_chk
    import qic_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [AW-1:0]     reg_addr,
    input logic [DW-1:0]     reg_rdata,
    input logic [HALF_Q-1:0] stat_lo,
    input logic [HALF_Q-1:0] stat_hi,
    input logic [HALF_Q-1:0] en_lo_q,
    input logic [HALF_Q-1:0] nne_q,
    input logic              irq_lo
);
    logic started;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) started <= 1'b0;
        else        started <= 1'b1;
    end

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (started && $past(reg_addr) < AW'(SEL_WORDS)) |-> ((reg_rdata & {QPW{4'h8}}) == '0)); // R2

    AST_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> ((stat_lo & ~$past(stat_lo) & ~$past(en_lo_q)) == '0)); // R5

    AST_HI_SET_NEEDS_NNE: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> ((stat_hi & ~$past(stat_hi) & ~$past(nne_q)) == '0)); // R4

    AST_DROP_NEEDS_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (started && !($past(reg_wr) && $past(reg_addr) == AW'(A_ST_LO)))
            |-> ((~stat_lo & $past(stat_lo)) == '0)); // R6

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (en_lo_q == '0) |-> !irq_lo); // R8
endmodule

bind queue_irq_ctrl queue_irq_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .stat_lo   (stat_lo),
    .stat_hi   (stat_hi),
    .en_lo_q   (en_lo_q),
    .nne_q     (nne_q),
    .irq_lo    (irq_lo)
);

// File: tb/queue_irq_ctrl_test.sv
module queue_irq_ctrl_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [3:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic [127:0] lo_flags = {32{4'h3}};
    logic [31:0]  hi_nne = '1;
    logic [31:0]  hi_full = '0;
    logic         irq_lo, irq_hi;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;  // 125 MHz

    queue_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lo_flags(lo_flags),
        .hi_nne(hi_nne), .hi_full(hi_full), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    // behavioural reference model
    bit [2:0]  m_sel [32];
    bit [3:0]  m_flag [32];
    bit [31:0] m_en_lo, m_en_hi, m_st_lo, m_st_hi, m_prev_lo, m_prev_hi;
    bit [31:0] m_nne, m_full, m_rd;

    function automatic bit [31:0] model_read(input int a);
        bit [31:0] v = 0;
        if (a < 4) begin
            for (int i = 0; i < 8; i++) v[i*4 +: 4] = {1'b0, m_sel[a*8+i]};
        end else if (a < 8) begin
            for (int i = 0; i < 8; i++) v[i*4 +: 4] = m_flag[(a-4)*8+i];
        end else begin
            case (a)
                8:  v = m_en_lo;
                9:  v = m_en_hi;
                10: v = m_st_lo;
                11: v = m_st_hi;
                12: v = m_nne;
                13: v = m_full;
                default: v = 0;
            endcase
        end
        return v;
    endfunction

    always @(posedge clk) begin : model
        bit [31:0] c_lo, clr_lo, clr_hi, rd;
        if (!rst_n) begin
            for (int q = 0; q < 32; q++) begin
                m_sel[q] = 0;
                m_flag[q] = 4'h3;
            end
            m_en_lo = 0; m_en_hi = 0; m_st_lo = 0; m_st_hi = 0;
            m_prev_lo = '1; m_prev_hi = '1; m_nne = '1; m_full = 0; m_rd = 0;
        end else begin
            for (int q = 0; q < 32; q++) c_lo[q] = m_flag[q][m_sel[q][1:0]] ^ m_sel[q][2];
            clr_lo = (reg_wr && reg_addr == 10) ? reg_wdata : 0;
            clr_hi = (reg_wr && reg_addr == 11) ? reg_wdata : 0;
            rd = model_read(int'(reg_addr));
            m_st_lo = (m_st_lo & ~clr_lo) | (m_en_lo & c_lo & ~m_prev_lo);
            m_st_hi = (m_st_hi & ~clr_hi) | (m_en_hi & m_nne & ~m_prev_hi);
            m_prev_lo = c_lo;
            m_prev_hi = m_nne;
            if (reg_wr) begin
                if (reg_addr < 4)
                    for (int i = 0; i < 8; i++) m_sel[int'(reg_addr)*8+i] = reg_wdata[i*4 +: 3];
                if (reg_addr == 8) m_en_lo = reg_wdata;
                if (reg_addr == 9) m_en_hi = reg_wdata;
            end
            for (int q = 0; q < 32; q++) m_flag[q] = lo_flags[q*4 +: 4];
            m_nne = hi_nne;
            m_full = hi_full;
            m_rd = rd;
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            tests++;
            if (irq_lo !== |(m_st_lo & m_en_lo)) begin
                fails++;
                $display("FAIL R8 irq_lo act=%0b exp=%0b", irq_lo, |(m_st_lo & m_en_lo));
            end
            tests++;
            if (irq_hi !== |(m_st_hi & m_en_hi)) begin
                fails++;
                $display("FAIL R8 irq_hi act=%0b exp=%0b", irq_hi, |(m_st_hi & m_en_hi));
            end
            tests++;
            if (reg_rdata !== m_rd) begin
                fails++;
                $display("FAIL R9 rdata act=%h exp=%h", reg_rdata, m_rd);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
        reg_addr = a;
        @(negedge clk);
        chk(req, reg_rdata, exp);
    endtask

    initial begin : wdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        chk("R1 irq_lo in reset", {31'b0, irq_lo}, 0);
        chk("R1 rdata in reset", reg_rdata, 0);
        rst_n = 1'b1;
        idle(1);
        rd_chk("R1 flag word", 4'd4, 32'h33333333);
        rd_chk("R1 sel word", 4'd0, 0);
        rd_chk("R1 en lo", 4'd8, 0);
        rd_chk("R1 status lo", 4'd10, 0);
        rd_chk("R1 nne word", 4'd12, 32'hFFFFFFFF);
        rd_chk("R1 full word", 4'd13, 0);

        // R2: reserved bits dropped
        wr(4'd1, 32'hFFFFFFFF);
        rd_chk("R2 sel reserved bits", 4'd1, 32'h77777777);
        wr(4'd1, 32'h00000020);   // queue 9 code 2 nearly full
        wr(4'd0, 32'h00004000);   // queue 3 code 4 not empty
        rd_chk("R2 sel word1", 4'd1, 32'h00000020);
        wr(4'd8, 32'h00000208);

        // R3: plain flag select
        lo_flags[39:36] = 4'h4;
        idle(3);
        rd_chk("R3 nearly-full rise", 4'd10, 32'h00000200);
        // R3: inverted select
        lo_flags[15:12] = 4'h0;
        idle(3);
        rd_chk("R3 inverted empty", 4'd10, 32'h00000208);

        // R6: write-1 clear
        wr(4'd10, 32'h00000200);
        rd_chk("R6 w1c", 4'd10, 32'h00000008);

        // R5: disabled queue 20
        lo_flags[83:80] = 4'h0;
        idle(2);
        lo_flags[83:80] = 4'h3;
        idle(3);
        rd_chk("R5 disabled no set", 4'd10, 32'h00000008);

        // R7: set beats clear
        lo_flags[15:12] = 4'h1;
        idle(3);
        wr(4'd10, 32'h00000008);
        idle(2);
        rd_chk("R7 pre clear", 4'd10, 0);
        lo_flags[15:12] = 4'h0;
        idle(1);
        wr(4'd10, 32'h00000008);
        idle(2);
        rd_chk("R7 set wins", 4'd10, 32'h00000008);

        // R8: disable drops irq, status held
        chk("R8 irq_lo high", {31'b0, irq_lo}, 1);
        wr(4'd8, 32'h00000200);
        chk("R8 irq_lo dropped", {31'b0, irq_lo}, 0);
        rd_chk("R8 status kept", 4'd10, 32'h00000008);
        wr(4'd10, 32'h00000008);

        // R4: upper half
        wr(4'd9, 32'h00000020);
        hi_nne[6:5] = 2'b00;
        hi_full = 32'h0000F000;
        idle(3);
        rd_chk("R10 nne capture", 4'd12, 32'hFFFFFF9F);
        hi_nne[6:5] = 2'b11;
        idle(3);
        rd_chk("R4 upper set", 4'd11, 32'h00000020);
        chk("R4 irq_hi", {31'b0, irq_hi}, 1);

        // R9 / R10: readback and read-only words
        rd_chk("R10 full capture", 4'd13, 32'h0000F000);
        wr(4'd4, 32'h0);
        rd_chk("R9 flag word write ignored", 4'd4, lo_flags[31:0]);
        wr(4'd13, 32'hFFFFFFFF);
        rd_chk("R9 full write ignored", 4'd13, 32'h0000F000);
        rd_chk("R9 unmapped", 4'd14, 0);
        rd_chk("R10 flag word2", 4'd6, lo_flags[95:64]);

        idle(2);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule